// File: doc/BRIEF.md
# Acknowledged Link Fault Detector

This block sits on one output port of a mesh router. It takes one flit at a time from the port's input side and keeps a copy in a one-entry hold buffer. It sends the flit to the downstream router and waits for an acknowledgment. If no acknowledgment comes back within a programmable number of cycles, it sends the same flit again and restarts the timer. Each port has its own count of resends.

When the number of resends goes past a programmable limit, the port is marked unsafe. The held flit is dropped, and the port refuses all further traffic until reset, so a route-selection stage must send packets out through another port.

The block also stores a congestion penalty that the neighbouring router writes. It presents that penalty next to the safe flag, so the route selector can prefer the less congested of its candidate ports.

Top module: `link_fault_detector`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, port_safe is 1 and port_penalty is 0.
- R2: When in_valid and in_ready are both high at a clock edge, out_valid is high for exactly the next cycle with out_data equal to the accepted word, and in_ready stays low while that word is outstanding.
- R3: An out_ack sampled high during any of the cfg_ack_timeout+1 cycles that start with an out_valid cycle frees the held word. in_ready returns to 1 in the following cycle and no resend occurs. If the acknowledgment and a timeout fall on the same edge, the acknowledgment takes precedence.
- R4: With cfg_ack_timeout of 1 or more and no acknowledgment in that window, out_valid rises again exactly cfg_ack_timeout+1 cycles after the previous pulse, carrying the same word.
- R5: When a timeout occurs after the resends already made for the current word exceed cfg_retry_limit (strictly greater), port_safe goes to 0 on the next cycle, the word is dropped and no further out_valid pulse is sent. A word therefore gets exactly cfg_retry_limit+1 resends, so a limit of 0 makes the port unsafe after the first failed resend.
- R6: Once port_safe is 0, it stays 0 until rst. While it is 0, in_ready and out_valid stay 0 whatever in_valid and out_ack do.
- R7: An acknowledgment clears the resend count, so each newly accepted word gets the full budget of cfg_retry_limit+1 resends.
- R8: An out_ack while no word is outstanding has no effect: in_ready stays 1, out_valid stays 0 and port_safe stays 1.
- R9: When nbr_pen_wr is high at an edge, port_penalty shows nbr_pen_val from the next cycle. Otherwise port_penalty holds its value, in either fault state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ack_timeout | input | TW | Cycles to wait for an acknowledgment beyond the send cycle |
| cfg_retry_limit | input | RW | Resend count that must be exceeded to mark the port unsafe |
| in_valid | input | 1 | A flit is offered for sending |
| in_data | input | DW | Offered flit |
| in_ready | output | 1 | Port is idle and safe and can take a flit |
| out_valid | output | 1 | One-cycle send or resend strobe toward the neighbour |
| out_data | output | DW | Flit on the link |
| out_ack | input | 1 | Acknowledgment from the downstream router |
| nbr_pen_wr | input | 1 | Neighbour penalty write strobe |
| nbr_pen_val | input | PW | Neighbour penalty value |
| port_safe | output | 1 | Port is usable for forwarding |
| port_penalty | output | PW | Stored congestion penalty |

## Verification
Flits are sent under several acknowledgment patterns, and each one separates a different fault in the timing and counting. An immediate acknowledgment checks that no resend is made. An acknowledgment after one timeout checks the resend spacing. An acknowledgment in the very last cycle of the window, after the full resend budget has been used, shows whether an acknowledgment beats a timeout on the same edge and whether the count is cleared for the next flit. A flit that is never acknowledged, run with limits of 1 and 0, pins the exact cycle at which the port turns unsafe, and so exposes an off-by-one in the strict comparison. Penalty writes, stray acknowledgments and offered traffic are then applied both before and after the port becomes unsafe.

// File: rtl/lfd_pkg.sv
package lfd_pkg;
  typedef enum logic {
    LFD_IDLE = 1'b0,
    LFD_WAIT = 1'b1
  } lfd_state_e;
endpackage

// File: rtl/lfd_ack_timer.sv
// Counts cycles spent waiting for an acknowledgment; restarts on each send.
module lfd_ack_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          at_limit
);
  logic [TW-1:0] cnt_q;

  assign at_limit = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (run && !at_limit) begin
      cnt_q <= cnt_q + TW'(1);
    end
  end
endmodule

// File: rtl/lfd_retry_guard.sv
// Resend counter with strict threshold compare and sticky fault flag.
module lfd_retry_guard #(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          bump,
  input  logic [RW-1:0] limit,
  output logic          trip,
  output logic          unsafe
);
  localparam int CW = RW + 1;
  logic [CW-1:0] cnt_q;
  logic          unsafe_q;

  assign trip   = bump && (cnt_q > {1'b0, limit});
  assign unsafe = unsafe_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (bump && !trip) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unsafe_q <= 1'b0;
    end else if (trip) begin
      unsafe_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lfd_penalty_reg.sv
// Neighbour-written congestion penalty.
module lfd_penalty_reg #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [PW-1:0] din,
  output logic [PW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr) begin
      q <= din;
    end
  end
endmodule

// File: rtl/link_fault_detector.sv
module link_fault_detector
  import lfd_pkg::*;
#(
  parameter int DW = 32,
  parameter int TW = 8,
  parameter int RW = 4,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] cfg_ack_timeout,
  input  logic [RW-1:0] cfg_retry_limit,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ack,
  input  logic          nbr_pen_wr,
  input  logic [PW-1:0] nbr_pen_val,
  output logic          port_safe,
  output logic [PW-1:0] port_penalty
);
  lfd_state_e    state_q;
  logic [DW-1:0] hold_q;
  logic          out_valid_q;
  logic          waiting, accept, ack_hit, at_limit, expired, trip, unsafe;

  assign waiting = (state_q == LFD_WAIT);
  assign ack_hit = waiting && out_ack;
  assign expired = waiting && at_limit && !ack_hit;
  assign in_ready = (state_q == LFD_IDLE) && !unsafe;
  assign accept  = in_valid && in_ready;

  lfd_ack_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .restart  (accept || (expired && !trip)),
    .run      (waiting && !ack_hit),
    .limit    (cfg_ack_timeout),
    .at_limit (at_limit)
  );

  lfd_retry_guard #(.RW(RW)) u_guard (
    .clk    (clk),
    .rst    (rst),
    .clear  (accept || ack_hit),
    .bump   (expired),
    .limit  (cfg_retry_limit),
    .trip   (trip),
    .unsafe (unsafe)
  );

  lfd_penalty_reg #(.PW(PW)) u_pen (
    .clk (clk),
    .rst (rst),
    .wr  (nbr_pen_wr),
    .din (nbr_pen_val),
    .q   (port_penalty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= LFD_IDLE;
      hold_q      <= '0;
      out_valid_q <= 1'b0;
    end else begin
      out_valid_q <= 1'b0;
      if (accept) begin
        hold_q      <= in_data;
        out_valid_q <= 1'b1;
        state_q     <= LFD_WAIT;
      end else if (ack_hit) begin
        state_q <= LFD_IDLE;
      end else if (expired) begin
        if (trip) begin
          state_q <= LFD_IDLE;
        end else begin
          out_valid_q <= 1'b1;
        end
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = hold_q;
  assign port_safe = !unsafe;
endmodule

// File: rtl/lfd_checker.sv
module lfd_checker #(
  parameter int DW = 32,
  parameter int TW = 8,
  parameter int RW = 4,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [TW-1:0] cfg_ack_timeout,
  input logic [RW-1:0] cfg_retry_limit,
  input logic          in_valid,
  input logic [DW-1:0] in_data,
  input logic          in_ready,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          out_ack,
  input logic          nbr_pen_wr,
  input logic [PW-1:0] nbr_pen_val,
  input logic          port_safe,
  input logic [PW-1:0] port_penalty
);
  p_accept_sends_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

  p_ack_frees_r3: assert property (@(posedge clk) disable iff (rst)
    (out_ack && !in_ready && port_safe) |=> in_ready);

  p_single_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cfg_ack_timeout != '0) |=> !out_valid);

  p_unsafe_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    !port_safe |=> !port_safe);

  p_unsafe_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    !port_safe |-> (!in_ready && !out_valid));

  p_pen_write_r9: assert property (@(posedge clk) disable iff (rst)
    nbr_pen_wr |=> (port_penalty == $past(nbr_pen_val)));

  p_pen_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !nbr_pen_wr |=> $stable(port_penalty));
endmodule

bind link_fault_detector lfd_checker #(.DW(DW), .TW(TW), .RW(RW), .PW(PW)) u_lfd_chk (
  .clk             (clk),
  .rst             (rst),
  .cfg_ack_timeout (cfg_ack_timeout),
  .cfg_retry_limit (cfg_retry_limit),
  .in_valid        (in_valid),
  .in_data         (in_data),
  .in_ready        (in_ready),
  .out_valid       (out_valid),
  .out_data        (out_data),
  .out_ack         (out_ack),
  .nbr_pen_wr      (nbr_pen_wr),
  .nbr_pen_val     (nbr_pen_val),
  .port_safe       (port_safe),
  .port_penalty    (port_penalty)
);

// File: tb/tb_link_fault_detector.sv
module tb_link_fault_detector;
  localparam int DW = 16;
  localparam int TW = 4;
  localparam int RW = 3;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] cfg_ack_timeout;
  logic [RW-1:0] cfg_retry_limit;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          out_ack = 1'b0;
  logic          nbr_pen_wr = 1'b0;
  logic [PW-1:0] nbr_pen_val = '0;
  logic          port_safe;
  logic [PW-1:0] port_penalty;

  int tmo = 3;
  int lim = 1;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] mon_exp;

  always #5 clk = ~clk;

  assign cfg_ack_timeout = TW'(tmo);
  assign cfg_retry_limit = RW'(lim);

  link_fault_detector #(.DW(DW), .TW(TW), .RW(RW), .PW(PW)) dut (
    .clk(clk), .rst(rst),
    .cfg_ack_timeout(cfg_ack_timeout), .cfg_retry_limit(cfg_retry_limit),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ack(out_ack),
    .nbr_pen_wr(nbr_pen_wr), .nbr_pen_val(nbr_pen_val),
    .port_safe(port_safe), .port_penalty(port_penalty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Monitor: every strobe must match the next queued word (R2, R4).
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 R4 unexpected out_valid", 1, 0);
      end else begin
        mon_exp = exp_q.pop_front();
        chk(out_data == mon_exp, "R2 R4 out_data", int'(out_data), int'(mon_exp));
      end
    end
  end

  // Driver: queue the word once per expected strobe, then offer it.
  task automatic launch(input logic [DW-1:0] d, input int npulse);
    for (int n = 0; n <= npulse; n++) exp_q.push_back(d);
    in_valid = 1'b1;
    in_data  = d;
    tick();
    in_valid = 1'b0;
  endtask

  // Offsets counted in cycles from the first strobe; strobes at k*(tmo+1).
  task automatic watch(input int from, input int upto, input int npulse, input string req);
    for (int off = from; off <= upto; off++) begin
      bit e;
      tick();
      e = (off % (tmo + 1) == 0) && (off / (tmo + 1) <= npulse);
      chk(out_valid == e, req, int'(out_valid), int'(e));
    end
  endtask

  task automatic ack_now();
    out_ack = 1'b1;
    tick();
    out_ack = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog all requirements actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(port_safe == 1'b1, "R1 port_safe", int'(port_safe), 1);
    chk(port_penalty == '0, "R1 port_penalty", int'(port_penalty), 0);

    // R8 stray ack while idle
    ack_now();
    chk(in_ready == 1'b1, "R8 in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R8 out_valid", int'(out_valid), 0);
    chk(port_safe == 1'b1, "R8 port_safe", int'(port_safe), 1);

    // R9 penalty write and hold
    nbr_pen_wr = 1'b1; nbr_pen_val = 4'd5;
    tick();
    nbr_pen_wr = 1'b0; nbr_pen_val = 4'd9;
    chk(port_penalty == 4'd5, "R9 write", int'(port_penalty), 5);
    repeat (3) tick();
    chk(port_penalty == 4'd5, "R9 hold", int'(port_penalty), 5);

    // R2/R3: immediate acknowledgment, no resend
    launch(16'hA11A, 0);
    chk(in_ready == 1'b0, "R2 busy", int'(in_ready), 0);
    ack_now();
    chk(in_ready == 1'b1, "R3 freed", int'(in_ready), 1);
    watch(2, 2 * (tmo + 1), 0, "R3 no resend");

    // R4: one resend then ack at the resend strobe
    launch(16'hB22B, 1);
    watch(1, tmo + 1, 1, "R4 resend spacing");
    ack_now();
    chk(in_ready == 1'b1, "R4 freed after resend", int'(in_ready), 1);

    // R7: full budget used, ack in the last window cycle
    launch(16'hC33C, 2);
    watch(1, 2 * (tmo + 1) + tmo, 2, "R7 budget");
    ack_now();
    chk(in_ready == 1'b1, "R7 late ack freed", int'(in_ready), 1);
    chk(port_safe == 1'b1, "R7 still safe", int'(port_safe), 1);
    chk(out_valid == 1'b0, "R3 ack beats timeout", int'(out_valid), 0);

    // R5: no ack; budget restored by R7, port trips after two resends
    launch(16'hD44D, 2);
    watch(1, 3 * (tmo + 1) - 1, 2, "R5 resends");
    chk(port_safe == 1'b1, "R5 safe before trip", int'(port_safe), 1);
    tick();
    chk(port_safe == 1'b0, "R5 trip", int'(port_safe), 0);
    chk(out_valid == 1'b0, "R5 no extra send", int'(out_valid), 0);
    chk(in_ready == 1'b0, "R5 blocked", int'(in_ready), 0);

    // R6: sticky and blocking; R9 write still works
    in_valid = 1'b1; in_data = 16'hE55E;
    for (int i = 0; i < 8; i++) begin
      out_ack = (i % 3 == 0);
      tick();
      chk(port_safe == 1'b0, "R6 sticky", int'(port_safe), 0);
      chk(in_ready == 1'b0, "R6 in_ready", int'(in_ready), 0);
      chk(out_valid == 1'b0, "R6 out_valid", int'(out_valid), 0);
    end
    in_valid = 1'b0; out_ack = 1'b0;
    nbr_pen_wr = 1'b1; nbr_pen_val = 4'd12;
    tick();
    nbr_pen_wr = 1'b0;
    chk(port_penalty == 4'd12, "R9 write while unsafe", int'(port_penalty), 12);

    // Reset clears the fault; limit 0 trips after the first failed resend
    rst = 1'b1; tmo = 2; lim = 0;
    repeat (2) tick();
    rst = 1'b0;
    tick();
    chk(port_safe == 1'b1, "R6 cleared by reset", int'(port_safe), 1);
    chk(port_penalty == '0, "R1 penalty after reset", int'(port_penalty), 0);
    launch(16'hF66F, 1);
    watch(1, 2 * (tmo + 1) - 1, 1, "R5 limit0 resend");
    chk(port_safe == 1'b1, "R5 limit0 before trip", int'(port_safe), 1);
    tick();
    chk(port_safe == 1'b0, "R5 limit0 trip", int'(port_safe), 0);
    chk(out_valid == 1'b0, "R5 limit0 no send", int'(out_valid), 0);

    tick();
    chk(exp_q.size() == 0, "R2 R4 missing strobes", exp_q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule